// File: doc/BRIEF.md
# Compare-Flag Arithmetic Logic Unit

This block is the execute-stage arithmetic/logic unit of a small 8-bit processor core. Each cycle it takes a 3-bit register-operation code and two operand values, the destination register's current value and the source register's value. It returns, without a clock edge in between, the value to write back, a write-back enable, and an indication that the operation is a memory access that the surrounding sequencer must handle. Load and store are only classified here; the register file, the memory cycle sequencing and the branch decision are built elsewhere.

A two-bit condition state (zero and no-borrow) is kept in registers inside the block. Only the compare operation changes it, on the clock edge in which a valid, non-flushed compare executes. Arithmetic never touches it. The carry flag means "no borrow": destination is greater than or equal to source, unsigned. The branch unit reads both flags from the ports.

Top module: `cmpflag_alu`

## Requirements
- R1: With opcode 000 (add), `result` equals (`rd_val` + `rs_val`) modulo 2^W.
- R2: With opcode 001 (subtract), `result` equals (`rd_val` - `rs_val`) modulo 2^W.
- R3: With opcode 010, `result` is the bitwise AND of the operands; with opcode 011, the bitwise OR.
- R4: With opcode 100 (move), `result` equals `rs_val`.
- R5: `wr_en` is 1 exactly when `op_valid`=1, `op_flush`=0 and the opcode is 000 through 100; it is 0 for 101 (compare), 110 (load) and 111 (store).
- R6: `mem_op` is 1 exactly when `op_valid`=1, `op_flush`=0 and the opcode is 110 or 111; `wr_en` and `mem_op` are never both 1.
- R7: On a rising edge where `op_valid`=1, `op_flush`=0 and the opcode is 101, `flag_z` becomes 1 iff `rd_val` equals `rs_val`, and `flag_c` becomes 1 iff `rd_val` >= `rs_val` unsigned; the new values show after that edge.
- R8: On any other edge without reset (other opcodes, `op_valid`=0, or `op_flush`=1), both flags keep their values.
- R9: A rising edge with `rst`=1 clears both flags to 0.
- R10: With opcode 110 or 111, `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | An instruction is in the execute stage this cycle |
| op_flush | input | 1 | The instruction in execute has been squashed |
| opcode | input | 3 | Register-operation code |
| rd_val | input | W | Destination register value (first operand) |
| rs_val | input | W | Source register value (second operand) |
| result | output | W | Write-back value |
| wr_en | output | 1 | Register write-back enable |
| mem_op | output | 1 | Operation is a load or store |
| flag_z | output | 1 | Registered zero flag from the last compare |
| flag_c | output | 1 | Registered no-borrow flag from the last compare |

## Verification
A wrong result or enable decode shows at the ports in the same cycle the opcode is applied, since that path holds no state. The only internal state is the flag pair: a compare that loads the wrong values, or a stray load from arithmetic, a flushed or an invalid slot, is visible on `flag_z`/`flag_c` just after the edge on which it happened, so the bench checks the flags after every single edge against its own flag model. Random compares with equal, lower and higher operands mixed with arithmetic and squashed slots catch both a bad update and a missing hold within one cycle.

// File: rtl/cmpflag_alu_pkg.sv
package cmpflag_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_MOV = 3'b100,
    OP_CMP = 3'b101,
    OP_LD  = 3'b110,
    OP_ST  = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic c;
  } flag_pair_t;

  function automatic logic op_writes_back(input alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
           (op == OP_OR)  || (op == OP_MOV);
  endfunction

  function automatic logic op_touches_mem(input alu_op_e op);
    return (op == OP_LD) || (op == OP_ST);
  endfunction

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
  import cmpflag_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y,
  output flag_pair_t     cmp_flags
);

  localparam int EW = W + 1;

  logic [EW-1:0] sum_x;
  logic [EW-1:0] dif_x;
  logic [W-1:0]  and_v;
  logic [W-1:0]  or_v;

  // one shared subtractor feeds SUB and the compare flags
  assign sum_x = {1'b0, a} + {1'b0, b};
  assign dif_x = {1'b0, a} - {1'b0, b};

  for (genvar i = 0; i < W; i++) begin : g_bitwise
    assign and_v[i] = a[i] & b[i];
    assign or_v[i]  = a[i] | b[i];
  end

  always_comb begin
    cmp_flags.z = (dif_x[W-1:0] == '0);
    cmp_flags.c = ~dif_x[W];
  end

  always_comb begin
    unique case (op)
      OP_ADD:  y = sum_x[W-1:0];
      OP_SUB:  y = dif_x[W-1:0];
      OP_AND:  y = and_v;
      OP_OR:   y = or_v;
      OP_MOV:  y = b;
      OP_CMP:  y = dif_x[W-1:0];
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/alu_decode.sv
module alu_decode
  import cmpflag_alu_pkg::*;
(
  input  logic    valid,
  input  logic    flush,
  input  alu_op_e op,
  output logic    wb_en,
  output logic    mem_en,
  output logic    cmp_fire
);

  logic live;

  assign live     = valid & ~flush;
  assign wb_en    = live & op_writes_back(op);
  assign mem_en   = live & op_touches_mem(op);
  assign cmp_fire = live & (op == OP_CMP);

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import cmpflag_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  flag_pair_t d,
  output flag_pair_t q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end

endmodule

// File: rtl/cmpflag_alu.sv
module cmpflag_alu
  import cmpflag_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic         op_flush,
  input  logic [2:0]   opcode,
  input  logic [W-1:0] rd_val,
  input  logic [W-1:0] rs_val,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic         mem_op,
  output logic         flag_z,
  output logic         flag_c
);

  alu_op_e    op;
  flag_pair_t cmp_next;
  flag_pair_t flags_q;
  logic       cmp_fire;

  assign op = alu_op_e'(opcode);

  alu_datapath #(.W(W)) u_dp (
    .op        (op),
    .a         (rd_val),
    .b         (rs_val),
    .y         (result),
    .cmp_flags (cmp_next)
  );

  alu_decode u_dec (
    .valid    (op_valid),
    .flush    (op_flush),
    .op       (op),
    .wb_en    (wr_en),
    .mem_en   (mem_op),
    .cmp_fire (cmp_fire)
  );

  alu_flag_reg u_flags (
    .clk  (clk),
    .rst  (rst),
    .load (cmp_fire),
    .d    (cmp_next),
    .q    (flags_q)
  );

  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;

endmodule

// File: rtl/cmpflag_alu_chk.sv
module cmpflag_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         op_valid,
  input logic         op_flush,
  input logic [2:0]   opcode,
  input logic [W-1:0] rd_val,
  input logic [W-1:0] rs_val,
  input logic [W-1:0] result,
  input logic         wr_en,
  input logic         mem_op,
  input logic         flag_z,
  input logic         flag_c
);

  logic fire;
  assign fire = op_valid && !op_flush && (opcode == 3'b101);

  p_add_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (opcode == 3'b000) |-> (result == W'(rd_val + rs_val)));

  p_sub_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (opcode == 3'b001) |-> (result == W'(rd_val - rs_val)));

  p_mov_pass_r4: assert property (@(posedge clk) disable iff (rst)
    (opcode == 3'b100) |-> (result == rs_val));

  p_no_wb_cmp_mem_r5: assert property (@(posedge clk) disable iff (rst)
    (opcode >= 3'b101) |-> !wr_en);

  p_wb_mem_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && mem_op));

  p_cmp_loads_z_r7: assert property (@(posedge clk) disable iff (rst)
    fire |=> (flag_z == $past(rd_val == rs_val)));

  p_cmp_loads_c_r7: assert property (@(posedge clk) disable iff (rst)
    fire |=> (flag_c == $past(rd_val >= rs_val)));

  p_flags_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !fire |=> ($stable(flag_z) && $stable(flag_c)));

  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> (!flag_z && !flag_c));

  p_mem_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (opcode >= 3'b110) |-> (result == '0));

endmodule

bind cmpflag_alu cmpflag_alu_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .op_flush (op_flush),
  .opcode   (opcode),
  .rd_val   (rd_val),
  .rs_val   (rs_val),
  .result   (result),
  .wr_en    (wr_en),
  .mem_op   (mem_op),
  .flag_z   (flag_z),
  .flag_c   (flag_c)
);

// File: tb/cmpflag_alu_tb.sv
module cmpflag_alu_tb;

  localparam int W = 8;
  localparam int NRAND = 3000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         op_valid = 1'b0;
  logic         op_flush = 1'b0;
  logic [2:0]   opcode = 3'b000;
  logic [W-1:0] rd_val = '0;
  logic [W-1:0] rs_val = '0;
  logic [W-1:0] result;
  logic         wr_en, mem_op, flag_z, flag_c;

  int n_chk = 0;
  int n_bad = 0;
  logic mz = 1'b0;
  logic mc = 1'b0;

  always #10 clk = ~clk;

  cmpflag_alu #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_flush(op_flush),
    .opcode(opcode), .rd_val(rd_val), .rs_val(rs_val), .result(result),
    .wr_en(wr_en), .mem_op(mem_op), .flag_z(flag_z), .flag_c(flag_c)
  );

  function automatic logic [W-1:0] exp_res(input logic [2:0] o,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] b);
    case (o)
      3'd0: return W'(a + b);
      3'd1: return W'(a - b);
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return b;
      3'd5: return W'(a - b);
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic f, input logic [2:0] o,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    logic live;
    @(negedge clk);
    op_valid = v; op_flush = f; opcode = o; rd_val = a; rs_val = b;
    live = v && !f;
    #2;
    if (o != 3'd5) check(req_of(o), "result", result, exp_res(o, a, b));
    check("R5", "wr_en", W'(wr_en), W'(live && (o <= 3'd4)));
    check("R6", "mem_op", W'(mem_op), W'(live && (o >= 3'd6)));
    @(posedge clk);
    if (live && o == 3'd5) begin
      mz = (a == b);
      mc = (a >= b);
    end
    #3;
    check((live && o == 3'd5) ? "R7" : "R8", "flag_z", W'(flag_z), W'(mz));
    check((live && o == 3'd5) ? "R7" : "R8", "flag_c", W'(flag_c), W'(mc));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    op_valid = 1'b0;
    @(posedge clk);
    #3;
    mz = 1'b0; mc = 1'b0;
    check("R9", "flag_z after reset", W'(flag_z), '0);
    check("R9", "flag_c after reset", W'(flag_c), '0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    do_reset();

    // R7: equal, below, above, extremes
    apply(1, 0, 3'd5, 8'h42, 8'h42);
    apply(1, 0, 3'd5, 8'h10, 8'h11);
    apply(1, 0, 3'd5, 8'h80, 8'h7F);
    apply(1, 0, 3'd5, 8'h00, 8'hFF);
    apply(1, 0, 3'd5, 8'hFF, 8'h00);
    apply(1, 0, 3'd5, 8'h00, 8'h00);
    // R8: arithmetic, flushed and idle compares leave flags (Z=1,C=1 now)
    apply(1, 0, 3'd1, 8'h05, 8'h09);
    apply(1, 1, 3'd5, 8'h01, 8'h02);
    apply(0, 0, 3'd5, 8'h01, 8'h02);
    apply(1, 0, 3'd0, 8'hFF, 8'h01);
    // R1/R2 wrap corners
    apply(1, 0, 3'd0, 8'hFF, 8'hFF);
    apply(1, 0, 3'd1, 8'h00, 8'h01);
    // R3/R4/R10 directed
    apply(1, 0, 3'd2, 8'hF0, 8'h3C);
    apply(1, 0, 3'd3, 8'hF0, 8'h0F);
    apply(1, 0, 3'd4, 8'hAA, 8'h55);
    apply(1, 0, 3'd6, 8'h12, 8'h34);
    apply(1, 0, 3'd7, 8'h12, 8'h34);
    apply(1, 1, 3'd7, 8'h12, 8'h34);
    // R9: reset in the middle clears set flags
    apply(1, 0, 3'd5, 8'h33, 8'h33);
    do_reset();

    for (int i = 0; i < NRAND; i++) begin
      logic [W-1:0] a, b;
      logic v, f;
      a = W'($urandom);
      b = ($urandom % 4 == 0) ? a : W'($urandom);
      v = ($urandom % 8) != 0;
      f = ($urandom % 6) == 0;
      apply(v, f, 3'($urandom), a, b);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule